// File: doc/BRIEF.md
# Center-Stage Crossbar Bid Arbiter

This block is one bufferless middle-stage crossbar of a three-stage buffered-unbuffered-buffered switch fabric, together with the bid controllers that sit on the input-module side of each crossbar link. Each input link holds at most one outstanding bid. A bid names a target output module, a queue inside that module and a service priority. In every slot (one clock cycle) the crossbar looks at all the held bids and at a per-queue "buffer free" vector sent up from the output modules. It grants at most one bid per output module and returns a three-way verdict for every bid.

A bid aimed at a queue with no free buffer is turned away with a backpressure code. That bid also drops out of contention for its output module. Among the remaining bids for one output module, the highest priority wins. Ties inside that priority are settled from a rotating start point taken from a free-running LFSR.

The link controller acts on the verdict at the slot boundary. On a grant it transmits the cell in the next slot and loads a fresh candidate in the same slot. On a contention loss it presents the identical bid again. On a backpressure rejection it drops the bid and loads the next candidate offered by the cell selector.

Top module: `xbar_bid_arbiter`

## Requirements
- R1: While reset is high and in the first cycle after it, every bid, feedback and transmit valid flag is 0 and every feedback code is 0.
- R2: In any slot, at most one bid per output module receives the success code, and an output module with at least one eligible bid grants exactly one.
- R3: Among eligible bids for the same output module, a bid with strictly higher priority value always wins over lower ones, which receive the lost code.
- R4: A bid whose queue flag in `q_avail` (bit index om*QPM+q) is 0 receives the backpressure code 2'b11 and never the success code 2'b01, even when it is the only bid for that module.
- R5: A backpressure-rejected bid takes no part in contention, so a lower-priority bid to a free queue of the same output module is granted.
- R6: Feedback is registered. `fb_valid[i]` and `fb_code[i]` appear one cycle after bid i was held on `bid_valid[i]`. `fb_valid` is 0 with code 2'b00 for an empty link. Codes: 01 success, 10 lost contention, 11 backpressure.
- R7: After a success, `xmit_valid[i]` is 1 in the next cycle with the granted bid's module and queue, and a waiting candidate is loaded as the new bid in the same cycle.
- R8: After a contention loss, the link holds the identical bid (module, queue, priority) into the next slot.
- R9: After a backpressure rejection, the link replaces the bid with the current candidate, or goes empty if none is offered.
- R10: An empty link, or one whose bid just succeeded or was rejected, raises `cand_pop[i]` for a valid candidate and holds it as its bid from the next cycle.
- R11: Bids to distinct output modules with free queues all succeed in the same slot.
- R12: With two equal-priority bids repeatedly contending for one output module, each wins at least once over 40 slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | NUM_IN | Candidate cell offered to each link |
| cand_om | input | NUM_IN*OM_W | Candidate target output module per link |
| cand_q | input | NUM_IN*Q_W | Candidate queue within the output module |
| cand_prio | input | NUM_IN*PRIO_W | Candidate service priority (larger wins) |
| q_avail | input | NUM_OUT*QPM | Buffer-free flag per output queue, bit om*QPM+q |
| cand_pop | output | NUM_IN | Candidate accepted as new bid at the coming edge |
| bid_valid | output | NUM_IN | Link holds a bid this slot |
| bid_om | output | NUM_IN*OM_W | Held bid's output module |
| bid_q | output | NUM_IN*Q_W | Held bid's queue |
| bid_prio | output | NUM_IN*PRIO_W | Held bid's priority |
| fb_valid | output | NUM_IN | Feedback present for the previous slot's bid |
| fb_code | output | NUM_IN*2 | Verdict: 00 none, 01 success, 10 lost, 11 backpressure |
| xmit_valid | output | NUM_IN | Cell of the last granted bid is sent this slot |
| xmit_om | output | NUM_IN*OM_W | Output module of the cell being sent |
| xmit_q | output | NUM_IN*Q_W | Queue of the cell being sent |

## Verification
Arbitration is exercised with a lone bid, three bids of differing priority on one module, bids split between a full and a free queue of one module, eight bids fanned out to eight modules, and two equal-priority bids contending for forty slots. The priority mix separates the priority ordering from the retry path, because each loser must reappear unchanged and win in a later slot. The full-versus-free pattern shows that a rejected bid neither wins nor blocks a lower one, and that the link swaps in a new candidate. The fan-out pattern catches false conflicts between modules, and the long tie run shows that the random start actually rotates.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic [1:0] {
    FB_NONE = 2'b00,
    FB_OK   = 2'b01,
    FB_LOST = 2'b10,
    FB_BP   = 2'b11
  } fb_code_e;
endpackage

// File: rtl/xbar_lfsr.sv
module xbar_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] state
);
  logic [W-1:0] st_q;

  always_ff @(posedge clk) begin
    if (rst) st_q <= SEED;
    else if (st_q[0]) st_q <= (st_q >> 1) ^ TAPS;
    else st_q <= st_q >> 1;
  end

  assign state = st_q;

  // LFSR must never lock up in the all-zero state (supports R12)
  p_lfsr_nonzero_r12: assert property (@(posedge clk) disable iff (rst) st_q != '0);
endmodule

// File: rtl/xbar_out_arb.sv
module xbar_out_arb #(
  parameter int NUM_IN = 8,
  parameter int PRIO_W = 2,
  parameter int IN_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_IN-1:0]        req,
  input  logic [NUM_IN*PRIO_W-1:0] prio,
  input  logic [IN_W-1:0]          start,
  output logic [NUM_IN-1:0]        win
);
  logic [PRIO_W-1:0] top_p;
  logic [NUM_IN-1:0] top_set;
  logic              found;

  always_comb begin
    top_p = '0;
    for (int i = 0; i < NUM_IN; i++)
      if (req[i] && prio[i*PRIO_W +: PRIO_W] > top_p) top_p = prio[i*PRIO_W +: PRIO_W];
    for (int i = 0; i < NUM_IN; i++)
      top_set[i] = req[i] && (prio[i*PRIO_W +: PRIO_W] == top_p);
  end

  always_comb begin
    win   = '0;
    found = 1'b0;
    for (int off = 0; off < NUM_IN; off++) begin
      int idx;
      idx = (int'(start) + off) % NUM_IN;
      if (!found && top_set[IN_W'(idx)]) begin
        win[IN_W'(idx)] = 1'b1;
        found = 1'b1;
      end
    end
  end

  // R2: one grant at most per output module
  p_one_winner_r2: assert property (@(posedge clk) disable iff (rst) $onehot0(win));
  // R2: any eligible request produces a grant
  p_req_gets_win_r2: assert property (@(posedge clk) disable iff (rst) (|req) |-> (|win));
endmodule

// File: rtl/xbar_link_ctrl.sv
module xbar_link_ctrl
  import xbar_pkg::*;
#(
  parameter int OM_W   = 3,
  parameter int Q_W    = 3,
  parameter int PRIO_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cand_valid,
  input  logic [OM_W-1:0]   cand_om,
  input  logic [Q_W-1:0]    cand_q,
  input  logic [PRIO_W-1:0] cand_prio,
  input  fb_code_e          res,
  output logic              cand_pop,
  output logic              bid_vld,
  output logic [OM_W-1:0]   bid_om,
  output logic [Q_W-1:0]    bid_q,
  output logic [PRIO_W-1:0] bid_prio,
  output logic              xmit_vld,
  output logic [OM_W-1:0]   xmit_om,
  output logic [Q_W-1:0]    xmit_q
);
  logic need_new;

  assign need_new = !bid_vld || (res == FB_OK) || (res == FB_BP);
  assign cand_pop = need_new && cand_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      bid_vld  <= 1'b0;
      bid_om   <= '0;
      bid_q    <= '0;
      bid_prio <= '0;
      xmit_vld <= 1'b0;
      xmit_om  <= '0;
      xmit_q   <= '0;
    end else begin
      xmit_vld <= bid_vld && (res == FB_OK);
      if (bid_vld && (res == FB_OK)) begin
        xmit_om <= bid_om;
        xmit_q  <= bid_q;
      end
      if (need_new) begin
        bid_vld <= cand_valid;
        if (cand_valid) begin
          bid_om   <= cand_om;
          bid_q    <= cand_q;
          bid_prio <= cand_prio;
        end
      end
    end
  end

  // R8: a lost bid is presented again unchanged
  p_lost_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (bid_vld && res == FB_LOST) |=> (bid_vld && $stable(bid_om) && $stable(bid_q) && $stable(bid_prio)));
  // R10: an accepted candidate becomes the held bid
  p_pop_loads_r10: assert property (@(posedge clk) disable iff (rst) cand_pop |=> bid_vld);
  // R7: a granted bid is transmitted in the next slot
  p_xmit_after_ok_r7: assert property (@(posedge clk) disable iff (rst)
    (bid_vld && res == FB_OK) |=> (xmit_vld && xmit_om == $past(bid_om) && xmit_q == $past(bid_q)));
endmodule

// File: rtl/xbar_bid_arbiter.sv
module xbar_bid_arbiter
  import xbar_pkg::*;
#(
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 8,
  parameter int QPM     = 5,
  parameter int PRIO_W  = 2,
  parameter int LFSR_W  = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  localparam int OM_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
  localparam int Q_W  = (QPM > 1) ? $clog2(QPM) : 1,
  localparam int IN_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_IN-1:0]        cand_valid,
  input  logic [NUM_IN*OM_W-1:0]   cand_om,
  input  logic [NUM_IN*Q_W-1:0]    cand_q,
  input  logic [NUM_IN*PRIO_W-1:0] cand_prio,
  input  logic [NUM_OUT*QPM-1:0]   q_avail,
  output logic [NUM_IN-1:0]        cand_pop,
  output logic [NUM_IN-1:0]        bid_valid,
  output logic [NUM_IN*OM_W-1:0]   bid_om,
  output logic [NUM_IN*Q_W-1:0]    bid_q,
  output logic [NUM_IN*PRIO_W-1:0] bid_prio,
  output logic [NUM_IN-1:0]        fb_valid,
  output logic [NUM_IN*2-1:0]      fb_code,
  output logic [NUM_IN-1:0]        xmit_valid,
  output logic [NUM_IN*OM_W-1:0]   xmit_om,
  output logic [NUM_IN*Q_W-1:0]    xmit_q
);
  localparam int AV_N = NUM_OUT * QPM;
  localparam int AV_W = (AV_N > 1) ? $clog2(AV_N) : 1;

  logic [LFSR_W-1:0] lfsr;
  logic [IN_W-1:0]   start;
  logic [NUM_IN-1:0] avail;
  logic [NUM_IN-1:0] elig;
  logic [NUM_IN-1:0] grant;
  logic [NUM_IN-1:0] req_om [NUM_OUT];
  logic [NUM_IN-1:0] win_om [NUM_OUT];
  fb_code_e          res    [NUM_IN];
  logic [NUM_IN-1:0] fb_vld_q;
  logic [NUM_IN*2-1:0] fb_code_q;

  xbar_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst(rst), .state(lfsr)
  );

  assign start = IN_W'(lfsr % LFSR_W'(NUM_IN));

  // Per-link bid controllers
  for (genvar i = 0; i < NUM_IN; i++) begin : g_link
    xbar_link_ctrl #(.OM_W(OM_W), .Q_W(Q_W), .PRIO_W(PRIO_W)) u_link (
      .clk       (clk),
      .rst       (rst),
      .cand_valid(cand_valid[i]),
      .cand_om   (cand_om[i*OM_W +: OM_W]),
      .cand_q    (cand_q[i*Q_W +: Q_W]),
      .cand_prio (cand_prio[i*PRIO_W +: PRIO_W]),
      .res       (res[i]),
      .cand_pop  (cand_pop[i]),
      .bid_vld   (bid_valid[i]),
      .bid_om    (bid_om[i*OM_W +: OM_W]),
      .bid_q     (bid_q[i*Q_W +: Q_W]),
      .bid_prio  (bid_prio[i*PRIO_W +: PRIO_W]),
      .xmit_vld  (xmit_valid[i]),
      .xmit_om   (xmit_om[i*OM_W +: OM_W]),
      .xmit_q    (xmit_q[i*Q_W +: Q_W])
    );
  end

  // Backpressure mask: queue must exist and report free buffer
  always_comb begin
    for (int i = 0; i < NUM_IN; i++) begin
      int om_i;
      int q_i;
      om_i = int'(bid_om[i*OM_W +: OM_W]);
      q_i  = int'(bid_q[i*Q_W +: Q_W]);
      if (om_i < NUM_OUT && q_i < QPM) avail[i] = q_avail[AV_W'(om_i * QPM + q_i)];
      else avail[i] = 1'b0;
      elig[i] = bid_valid[i] && avail[i];
    end
  end

  // One arbiter per output module
  for (genvar j = 0; j < NUM_OUT; j++) begin : g_om
    always_comb begin
      for (int i = 0; i < NUM_IN; i++)
        req_om[j][i] = elig[i] && (int'(bid_om[i*OM_W +: OM_W]) == j);
    end
    xbar_out_arb #(.NUM_IN(NUM_IN), .PRIO_W(PRIO_W), .IN_W(IN_W)) u_arb (
      .clk  (clk),
      .rst  (rst),
      .req  (req_om[j]),
      .prio (bid_prio),
      .start(start),
      .win  (win_om[j])
    );
  end

  always_comb begin
    grant = '0;
    for (int j = 0; j < NUM_OUT; j++) grant = grant | win_om[j];
    for (int i = 0; i < NUM_IN; i++) begin
      if (!bid_valid[i])  res[i] = FB_NONE;
      else if (!avail[i]) res[i] = FB_BP;
      else if (grant[i])  res[i] = FB_OK;
      else                res[i] = FB_LOST;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_vld_q  <= '0;
      fb_code_q <= '0;
    end else begin
      fb_vld_q <= bid_valid;
      for (int i = 0; i < NUM_IN; i++) fb_code_q[i*2 +: 2] <= res[i];
    end
  end

  assign fb_valid = fb_vld_q;
  assign fb_code  = fb_code_q;

  // R6: feedback flags track the bids held one slot earlier
  p_fb_valid_r6: assert property (@(posedge clk) disable iff (rst) fb_valid == $past(bid_valid));

  for (genvar i = 0; i < NUM_IN; i++) begin : g_chk
    // R4: a granted bid always had a free queue
    p_bp_never_ok_r4: assert property (@(posedge clk) disable iff (rst)
      (fb_code[i*2 +: 2] == 2'b01) |-> $past(avail[i]));
    // R7: every success shows up as a transmit in the same cycle as its feedback
    p_ok_means_xmit_r7: assert property (@(posedge clk) disable iff (rst)
      (fb_code[i*2 +: 2] == 2'b01) |-> xmit_valid[i]);
  end
endmodule

// File: tb/xbar_bid_arbiter_tb_top.sv
module xbar_bid_arbiter_tb_top;
  localparam int NI = 8, NO = 8, QP = 5, PW = 2, OW = 3, QW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [NI-1:0]    cand_valid;
  logic [NI*OW-1:0] cand_om;
  logic [NI*QW-1:0] cand_q;
  logic [NI*PW-1:0] cand_prio;
  logic [NO*QP-1:0] q_avail;
  logic [NI-1:0]    cand_pop, bid_valid, fb_valid, xmit_valid;
  logic [NI*OW-1:0] bid_om, xmit_om;
  logic [NI*QW-1:0] bid_q, xmit_q;
  logic [NI*PW-1:0] bid_prio;
  logic [NI*2-1:0]  fb_code;

  logic          c_v [NI];
  logic [OW-1:0] c_om[NI];
  logic [QW-1:0] c_q [NI];
  logic [PW-1:0] c_p [NI];

  always_comb
    for (int i = 0; i < NI; i++) begin
      cand_valid[i]           = c_v[i];
      cand_om[i*OW +: OW]     = c_om[i];
      cand_q[i*QW +: QW]      = c_q[i];
      cand_prio[i*PW +: PW]   = c_p[i];
    end

  xbar_bid_arbiter dut_i (
    .clk(clk), .rst(rst), .cand_valid(cand_valid), .cand_om(cand_om), .cand_q(cand_q),
    .cand_prio(cand_prio), .q_avail(q_avail), .cand_pop(cand_pop), .bid_valid(bid_valid),
    .bid_om(bid_om), .bid_q(bid_q), .bid_prio(bid_prio), .fb_valid(fb_valid),
    .fb_code(fb_code), .xmit_valid(xmit_valid), .xmit_om(xmit_om), .xmit_q(xmit_q)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int fbc(int i); return int'(fb_code[i*2 +: 2]); endfunction

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  task automatic set_c(int i, int om, int q, int p);
    c_v[i] = 1'b1; c_om[i] = OW'(om); c_q[i] = QW'(q); c_p[i] = PW'(p);
  endtask

  task automatic clr_all();
    for (int i = 0; i < NI; i++) c_v[i] = 1'b0;
  endtask

  task automatic drain();
    clr_all(); q_avail = '1;
    repeat (12) step();
  endtask

  task automatic t_reset();
    chk("R1 bid_valid", int'(bid_valid), 0);
    chk("R1 fb_valid", int'(fb_valid), 0);
    chk("R1 xmit_valid", int'(xmit_valid), 0);
    chk("R1 fb_code", int'(fb_code), 0);
  endtask

  task automatic t_single();
    set_c(0, 2, 1, 0);
    #1 chk("R10 pop on empty link", int'(cand_pop[0]), 1);
    step(); clr_all();
    chk("R10 bid loaded", int'(bid_valid[0]), 1);
    chk("R10 bid om", int'(bid_om[0 +: OW]), 2);
    chk("R6 no feedback yet", int'(fb_valid[0]), 0);
    step();
    chk("R6 fb_valid", int'(fb_valid[0]), 1);
    chk("R6 success code", fbc(0), 1);
    chk("R7 xmit_valid", int'(xmit_valid[0]), 1);
    chk("R7 xmit om", int'(xmit_om[0 +: OW]), 2);
    chk("R7 xmit q", int'(xmit_q[0 +: QW]), 1);
    chk("R7 link empty with no candidate", int'(bid_valid[0]), 0);
    drain();
  endtask

  task automatic t_prio();
    set_c(0, 3, 0, 1); set_c(1, 3, 2, 2); set_c(2, 3, 4, 0);
    step(); clr_all();
    step();
    chk("R3 top priority wins", fbc(1), 1);
    chk("R3 mid loses", fbc(0), 2);
    chk("R3 low loses", fbc(2), 2);
    chk("R8 held valid", int'(bid_valid[0]), 1);
    chk("R8 held om", int'(bid_om[0 +: OW]), 3);
    chk("R8 held prio", int'(bid_prio[0 +: PW]), 1);
    chk("R8 held q input2", int'(bid_q[2*QW +: QW]), 4);
    step();
    chk("R3 retry mid wins", fbc(0), 1);
    chk("R8 low still lost", fbc(2), 2);
    step();
    chk("R8 low finally wins", fbc(2), 1);
    drain();
  endtask

  task automatic t_bp();
    q_avail[4*QP + 2] = 1'b0;
    set_c(0, 4, 2, 3); set_c(1, 4, 0, 0);
    step();
    clr_all(); set_c(0, 5, 1, 0);
    #1 chk("R10 pop after reject", int'(cand_pop[0]), 1);
    step(); clr_all();
    chk("R4 backpressure code", fbc(0), 3);
    chk("R5 lower prio free queue wins", fbc(1), 1);
    chk("R9 replaced bid valid", int'(bid_valid[0]), 1);
    chk("R9 replaced bid om", int'(bid_om[0 +: OW]), 5);
    chk("R9 replaced bid q", int'(bid_q[0 +: QW]), 1);
    step();
    chk("R9 new cell wins", fbc(0), 1);
    set_c(2, 4, 2, 0);
    step(); clr_all();
    step();
    chk("R4 lone bid rejected", fbc(2), 3);
    chk("R4 no xmit", int'(xmit_valid[2]), 0);
    chk("R9 empty without candidate", int'(bid_valid[2]), 0);
    drain();
  endtask

  task automatic t_fanout();
    for (int i = 0; i < NI; i++) set_c(i, i, i % QP, i % 4);
    step(); clr_all();
    step();
    for (int i = 0; i < NI; i++) chk("R11 distinct modules succeed", fbc(i), 1);
    drain();
  endtask

  task automatic t_tie();
    int w0 = 0, w1 = 0;
    set_c(0, 6, 3, 2); set_c(1, 6, 1, 2);
    step();
    for (int s = 0; s < 40; s++) begin
      int oks;
      step();
      oks = (fbc(0) == 1 ? 1 : 0) + (fbc(1) == 1 ? 1 : 0);
      chk("R2 exactly one tie winner", oks, 1);
      if (fbc(0) == 1) w0++;
      if (fbc(1) == 1) w1++;
    end
    chk("R12 input0 won some", int'(w0 > 0), 1);
    chk("R12 input1 won some", int'(w1 > 0), 1);
    drain();
  endtask

  task automatic t_idle();
    step();
    chk("R6 idle fb_valid", int'(fb_valid), 0);
    chk("R6 idle codes", int'(fb_code), 0);
  endtask

  initial begin
    clr_all();
    for (int i = 0; i < NI; i++) begin c_om[i] = '0; c_q[i] = '0; c_p[i] = '0; end
    q_avail = '1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    step();
    t_reset();
    t_single();
    t_prio();
    t_bp();
    t_fanout();
    t_tie();
    t_idle();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule